// File: doc/BRIEF.md
# Accumulator ALU with Skip Evaluation

This block is the execute-stage datapath of a small 16-bit accumulator machine. Each cycle in which the sequencer marks an instruction as executing, the block takes the current accumulator, the memory buffer operand and the index register. It returns the value to write back into the accumulator, and for double-length shifts also the index register. All results are combinational within the execute cycle. Write-enable outputs tell the sequencer which registers to update.

The machine has no conditional branch. Compare instructions set three registered magnitude flags: less-than, equal and greater-than. These flags persist until the next compare. A skip instruction tests one of sixteen condition codes, drawn from the accumulator, the index register, the stored flags or four external switch inputs. When the tested condition holds, the block raises `skip` for that execute cycle only. The sequencer then advances the program counter by two words instead of one, so a jump placed after the skip behaves as a conditional branch.

Opcode (5 bits, `op_code`): 0 no-op, 1 add, 2 subtract, 3 AND, 4 inclusive OR, 5 exclusive OR, 6 invert, 7 negate, 8 shift left, 9 shift right, 10 rotate left, 11 rotate right, 12–15 the same four in 32-bit form, 16 word compare, 17 byte compare, 18 literal byte compare, 19 literal byte load, 20 skip. Codes 21–31 are unused.

Top module: `acc_alu_unit`

## Requirements
- R1: With `exec_valid` high, opcodes 1, 2, 3, 4 and 5 set `acc_res` to acc+mbr, acc−mbr, acc&mbr, acc|mbr and acc^mbr respectively, modulo 2^16. `acc_we` is high and `idx_we` is low.
- R2: Opcode 6 sets `acc_res` to the bitwise complement of `acc_in`. Opcode 7 sets it to the two's complement (0 maps to 0, 0x8000 to 0x8000). `acc_we` is high.
- R3: Opcodes 8/9/10/11 shift left, shift right, rotate left and rotate right the accumulator by `fld_imm[3:0]`+1 positions (1 to 16). Logical shifts fill with zeros, so a count of 16 gives 0 and a rotate by 16 returns the input. Only `acc_we` is high.
- R4: Opcodes 12–15 apply the same four operations to the 32-bit word {acc_in, idx_in}, with the accumulator as the upper half. `acc_res` carries the upper half and `idx_res` the lower half, and both `acc_we` and `idx_we` are high.
- R5: Opcodes 16, 17 and 18 compare unsigned: acc with mbr (16 bits), acc[7:0] with mbr[7:0], and acc[7:0] with `fld_imm`. Exactly one of `flag_lt`, `flag_eq`, `flag_gt` is set from the clock edge that ends the execute cycle, with lt meaning acc is the smaller. Compares assert neither write enable.
- R6: The flags are all zero after reset. They keep their value through every cycle that is not an executing compare.
- R7: Opcode 19 sets `acc_res` to {8'h00, fld_imm} with `acc_we` high.
- R8: Opcode 20 raises `skip` in its execute cycle when the condition `fld_imm[3:0]` holds. The codes are: 0 acc==0, 1 acc!=0, 2 acc[15], 3 idx==0, 4 idx[15], 5 lt, 6 eq, 7 gt, 8–11 `sw_in[0..3]` high, 12–15 never. A skip writes no register.
- R9: With `exec_valid` low, or with opcode 0 or 21–31, `acc_we`, `idx_we` and `skip` are low and `acc_res`/`idx_res` equal `acc_in`/`idx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_valid | input | 1 | Instruction is in its execute cycle |
| op_code | input | 5 | Operation select |
| fld_imm | input | 8 | Instruction literal: byte constant, shift count, or skip condition |
| acc_in | input | 16 | Current accumulator |
| mbr_in | input | 16 | Memory buffer operand |
| idx_in | input | 16 | Current index register |
| sw_in | input | 4 | External switch levels |
| acc_res | output | 16 | New accumulator value |
| acc_we | output | 1 | Accumulator write enable |
| idx_res | output | 16 | New index register value |
| idx_we | output | 1 | Index register write enable |
| flag_lt | output | 1 | Last compare: accumulator side smaller |
| flag_eq | output | 1 | Last compare: equal |
| flag_gt | output | 1 | Last compare: accumulator side larger |
| skip | output | 1 | Skip the next instruction |

## Verification
Every cycle, the assertions check the following:
- add and subtract results are consistent with their operands;
- negation sums to zero;
- a rotate by the full count preserves the accumulator;
- double-length operations write both registers;
- a compare leaves exactly one flag set;
- the flags hold when no compare executes;
- the literal load is correct;
- idle cycles and skips write nothing.

The exact results of every shift count on each opcode, the unsigned ordering and byte selection of the three compare forms, and each of the sixteen skip codes against accumulator, index, flag and switch states are shown only by the bench's sweeps. These are compared with values the bench computes arithmetically.

// File: rtl/aalu_pkg.sv
package aalu_pkg;
  typedef enum logic [4:0] {
    OP_NOP = 5'd0,
    OP_ADD = 5'd1,
    OP_SUB = 5'd2,
    OP_AND = 5'd3,
    OP_IOR = 5'd4,
    OP_XOR = 5'd5,
    OP_INV = 5'd6,
    OP_NEG = 5'd7,
    OP_SHL = 5'd8,
    OP_SHR = 5'd9,
    OP_ROL = 5'd10,
    OP_ROR = 5'd11,
    OP_DSL = 5'd12,
    OP_DSR = 5'd13,
    OP_DRL = 5'd14,
    OP_DRR = 5'd15,
    OP_CMW = 5'd16,
    OP_CMB = 5'd17,
    OP_CLB = 5'd18,
    OP_LLB = 5'd19,
    OP_SKP = 5'd20
  } aalu_op_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } cmp_flags_t;

  localparam int unsigned SKIP_SEL_W = 4;
  localparam int unsigned SKIP_SW_BASE = 8;
endpackage

// File: rtl/aalu_logic.sv
module aalu_logic
  import aalu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  aalu_op_e          op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              hit
);
  always_comb begin
    hit = 1'b1;
    res = a;
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_IOR:  res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INV:  res = ~a;
      OP_NEG:  res = (~a) + DATA_W'(1);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/aalu_shift.sv
module aalu_shift #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned AMT_W = 5
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  logic             to_left,
  input  logic             rotate,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned DBL_W = 2 * WIDTH;

  logic [DBL_W-1:0] dbl_l;
  logic [DBL_W-1:0] dbl_r;
  logic [WIDTH-1:0] lin_l;
  logic [WIDTH-1:0] lin_r;

  always_comb begin
    dbl_l = {din, din} << amt;
    dbl_r = {din, din} >> amt;
    lin_l = din << amt;
    lin_r = din >> amt;
    unique case ({to_left, rotate})
      2'b10:   dout = lin_l;
      2'b11:   dout = dbl_l[DBL_W-1:WIDTH];
      2'b01:   dout = dbl_r[WIDTH-1:0];
      default: dout = lin_r;
    endcase
  end
endmodule

// File: rtl/aalu_cmp.sv
module aalu_cmp
  import aalu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output cmp_flags_t        flags
);
  always_comb begin
    flags.lt = (a < b);
    flags.eq = (a == b);
    flags.gt = (a > b);
  end
endmodule

// File: rtl/aalu_skip.sv
module aalu_skip
  import aalu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SW_N   = 4
) (
  input  logic [SKIP_SEL_W-1:0] sel,
  input  logic [DATA_W-1:0]     acc,
  input  logic [DATA_W-1:0]     idx,
  input  cmp_flags_t            flags,
  input  logic [SW_N-1:0]       sw,
  output logic                  take
);
  localparam int unsigned NCOND  = 1 << SKIP_SEL_W;
  localparam int unsigned SW_SLOTS = NCOND - SKIP_SW_BASE;

  logic [SKIP_SW_BASE-1:0] base_cond;
  logic [SW_SLOTS-1:0]     sw_cond;

  always_comb begin
    base_cond[0] = (acc == '0);
    base_cond[1] = (acc != '0);
    base_cond[2] = acc[DATA_W-1];
    base_cond[3] = (idx == '0);
    base_cond[4] = idx[DATA_W-1];
    base_cond[5] = flags.lt;
    base_cond[6] = flags.eq;
    base_cond[7] = flags.gt;
  end

  for (genvar g = 0; g < SW_SLOTS; g++) begin : g_sw
    if (g < SW_N) begin : g_used
      assign sw_cond[g] = sw[g];
    end else begin : g_never
      assign sw_cond[g] = 1'b0;
    end
  end

  logic [NCOND-1:0] all_cond;
  assign all_cond = {sw_cond, base_cond};
  assign take     = all_cond[sel];
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import aalu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned SW_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_valid,
  input  logic [4:0]        op_code,
  input  logic [BYTE_W-1:0] fld_imm,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mbr_in,
  input  logic [DATA_W-1:0] idx_in,
  input  logic [SW_N-1:0]   sw_in,
  output logic [DATA_W-1:0] acc_res,
  output logic              acc_we,
  output logic [DATA_W-1:0] idx_res,
  output logic              idx_we,
  output logic              flag_lt,
  output logic              flag_eq,
  output logic              flag_gt,
  output logic              skip
);
  localparam int unsigned AMT_W  = CNT_W + 1;
  localparam int unsigned DBL_W  = 2 * DATA_W;
  localparam int unsigned HIGH_W = DATA_W - BYTE_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  aalu_op_e op;
  assign op = aalu_op_e'(op_code);

  // logic / arithmetic
  logic [DATA_W-1:0] lu_res;
  logic              lu_hit;
  aalu_logic #(.DATA_W(DATA_W)) u_logic (
    .op (op),
    .a  (acc_in),
    .b  (mbr_in),
    .res(lu_res),
    .hit(lu_hit)
  );

  // shifters
  logic [AMT_W-1:0] sh_amt;
  logic             sh_left;
  logic             sh_rot;
  logic             sh_single;
  logic             sh_double;
  assign sh_amt    = {1'b0, fld_imm[CNT_W-1:0]} + AMT_W'(1);
  assign sh_left   = (op == OP_SHL) || (op == OP_ROL) || (op == OP_DSL) || (op == OP_DRL);
  assign sh_rot    = (op == OP_ROL) || (op == OP_ROR) || (op == OP_DRL) || (op == OP_DRR);
  assign sh_single = (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) || (op == OP_ROR);
  assign sh_double = (op == OP_DSL) || (op == OP_DSR) || (op == OP_DRL) || (op == OP_DRR);

  logic [DATA_W-1:0] sh16_out;
  logic [DBL_W-1:0]  sh32_out;
  aalu_shift #(.WIDTH(DATA_W), .AMT_W(AMT_W)) u_shift_single (
    .din    (acc_in),
    .amt    (sh_amt),
    .to_left(sh_left),
    .rotate (sh_rot),
    .dout   (sh16_out)
  );
  aalu_shift #(.WIDTH(DBL_W), .AMT_W(AMT_W)) u_shift_double (
    .din    ({acc_in, idx_in}),
    .amt    (sh_amt),
    .to_left(sh_left),
    .rotate (sh_rot),
    .dout   (sh32_out)
  );

  // comparison
  logic [DATA_W-1:0] cmp_a;
  logic [DATA_W-1:0] cmp_b;
  logic              is_cmp;
  cmp_flags_t        cmp_now;
  always_comb begin
    is_cmp = 1'b1;
    cmp_a  = {{HIGH_W{1'b0}}, acc_in[BYTE_W-1:0]};
    cmp_b  = {{HIGH_W{1'b0}}, mbr_in[BYTE_W-1:0]};
    unique case (op)
      OP_CMW: begin
        cmp_a = acc_in;
        cmp_b = mbr_in;
      end
      OP_CMB: ;
      OP_CLB:  cmp_b = {{HIGH_W{1'b0}}, fld_imm};
      default: is_cmp = 1'b0;
    endcase
  end

  aalu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a    (cmp_a),
    .b    (cmp_b),
    .flags(cmp_now)
  );

  // flag register: next-state and register processes
  cmp_flags_t flags_q;
  cmp_flags_t flags_d;
  logic       flag_en;
  assign flag_en = exec_valid && is_cmp;

  always_comb begin
    flags_d = flags_q;
    if (flag_en) flags_d = cmp_now;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end

  assign flag_lt = flags_q.lt;
  assign flag_eq = flags_q.eq;
  assign flag_gt = flags_q.gt;

  // skip
  logic skip_cond;
  aalu_skip #(.DATA_W(DATA_W), .SW_N(SW_N)) u_skip (
    .sel  (fld_imm[SKIP_SEL_W-1:0]),
    .acc  (acc_in),
    .idx  (idx_in),
    .flags(flags_q),
    .sw   (sw_in),
    .take (skip_cond)
  );
  assign skip = exec_valid && (op == OP_SKP) && skip_cond;

  // result selection
  always_comb begin
    acc_res = acc_in;
    idx_res = idx_in;
    acc_we  = 1'b0;
    idx_we  = 1'b0;
    if (exec_valid) begin
      if (lu_hit) begin
        acc_res = lu_res;
        acc_we  = 1'b1;
      end else if (sh_single) begin
        acc_res = sh16_out;
        acc_we  = 1'b1;
      end else if (sh_double) begin
        acc_res = sh32_out[DBL_W-1:DATA_W];
        idx_res = sh32_out[DATA_W-1:0];
        acc_we  = 1'b1;
        idx_we  = 1'b1;
      end else if (op == OP_LLB) begin
        acc_res = {{HIGH_W{1'b0}}, fld_imm};
        acc_we  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/aalu_chk.sv
module aalu_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              exec_valid,
  input logic [4:0]        op_code,
  input logic [BYTE_W-1:0] fld_imm,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] mbr_in,
  input logic [DATA_W-1:0] acc_res,
  input logic              acc_we,
  input logic              idx_we,
  input logic              flag_lt,
  input logic              flag_eq,
  input logic              flag_gt,
  input logic              skip
);
  logic cmp_exec;
  assign cmp_exec = exec_valid && (op_code >= 5'd16) && (op_code <= 5'd18);

  assert_add_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_valid && op_code == 5'd1) |-> (DATA_W'(acc_res - mbr_in) == acc_in));

  assert_sub_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_valid && op_code == 5'd2) |-> (DATA_W'(acc_res + mbr_in) == acc_in));

  assert_neg_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_valid && op_code == 5'd7) |-> (DATA_W'(acc_res + acc_in) == '0));

  assert_full_rotate_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_valid && (op_code == 5'd10 || op_code == 5'd11) && fld_imm[CNT_W-1:0] == {CNT_W{1'b1}})
    |-> (acc_res == acc_in));

  assert_dword_writes_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_valid && op_code >= 5'd12 && op_code <= 5'd15) |-> (acc_we && idx_we));

  assert_one_flag_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    cmp_exec |=> ($countones({flag_lt, flag_eq, flag_gt}) == 1));

  assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    cmp_exec |-> (!acc_we && !idx_we));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    !cmp_exec |=> $stable({flag_lt, flag_eq, flag_gt}));

  assert_llb_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_valid && op_code == 5'd19) |-> (acc_we && acc_res[BYTE_W-1:0] == fld_imm &&
                                          acc_res[DATA_W-1:BYTE_W] == '0));

  assert_skip_source_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    skip |-> (exec_valid && op_code == 5'd20 && !acc_we && !idx_we));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !exec_valid |-> (!acc_we && !idx_we && !skip));
endmodule

bind acc_alu_unit aalu_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .exec_valid(exec_valid),
  .op_code   (op_code),
  .fld_imm   (fld_imm),
  .acc_in    (acc_in),
  .mbr_in    (mbr_in),
  .acc_res   (acc_res),
  .acc_we    (acc_we),
  .idx_we    (idx_we),
  .flag_lt   (flag_lt),
  .flag_eq   (flag_eq),
  .flag_gt   (flag_gt),
  .skip      (skip)
);

// File: tb/tb_acc_alu_unit.sv
module tb_acc_alu_unit;
  logic        clk;
  logic        rst_n;
  logic        exec_valid;
  logic [4:0]  op_code;
  logic [7:0]  fld_imm;
  logic [15:0] acc_in;
  logic [15:0] mbr_in;
  logic [15:0] idx_in;
  logic [3:0]  sw_in;
  logic [15:0] acc_res;
  logic        acc_we;
  logic [15:0] idx_res;
  logic        idx_we;
  logic        flag_lt;
  logic        flag_eq;
  logic        flag_gt;
  logic        skip;

  int checks = 0;
  int fails  = 0;

  acc_alu_unit dut (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .op_code(op_code),
    .fld_imm(fld_imm), .acc_in(acc_in), .mbr_in(mbr_in), .idx_in(idx_in),
    .sw_in(sw_in), .acc_res(acc_res), .acc_we(acc_we), .idx_res(idx_res),
    .idx_we(idx_we), .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_gt(flag_gt),
    .skip(skip)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h op=%0d fld=%h acc=%h mbr=%h idx=%h",
               req, got, exp, op_code, fld_imm, acc_in, mbr_in, idx_in);
    end
  endtask

  task automatic run(input logic [4:0] op, input logic [7:0] f,
                     input logic [15:0] a, input logic [15:0] m, input logic [15:0] x);
    @(negedge clk);
    exec_valid = 1'b1;
    op_code = op; fld_imm = f; acc_in = a; mbr_in = m; idx_in = x;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    exec_valid = 1'b0;
    op_code = 5'd16;
    #1;
  endtask

  function automatic logic [15:0] val(input int k);
    case (k)
      0: val = 16'h0000;
      1: val = 16'h0001;
      2: val = 16'h7FFF;
      3: val = 16'h8000;
      4: val = 16'hFFFF;
      5: val = 16'h00FF;
      6: val = 16'hFF00;
      7: val = 16'hAAAA;
      default: val = 16'((k * 40503) ^ (k << 7));
    endcase
  endfunction

  function automatic logic [15:0] exp_sh16(input int op, input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      case (op)
        8:  v = {v[14:0], 1'b0};
        9:  v = {1'b0, v[15:1]};
        10: v = {v[14:0], v[15]};
        default: v = {v[0], v[15:1]};
      endcase
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_sh32(input int op, input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      case (op)
        12: v = {v[30:0], 1'b0};
        13: v = {1'b0, v[31:1]};
        14: v = {v[30:0], v[31]};
        default: v = {v[0], v[31:1]};
      endcase
    end
    return v;
  endfunction

  function automatic logic [2:0] exp_flags(input int a, input int b);
    if (a < b)       return 3'b100;
    else if (a == b) return 3'b010;
    else             return 3'b001;
  endfunction

  initial begin
    #(5 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exec_valid = 1'b0; op_code = 5'd0; fld_imm = 8'd0;
    acc_in = 16'd0; mbr_in = 16'd0; idx_in = 16'd0; sw_in = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // reset state R6, idle R9
    chk("R6 reset flags", {29'd0, flag_lt, flag_eq, flag_gt}, 32'd0);
    chk("R9 reset idle", {29'd0, acc_we, idx_we, skip}, 32'd0);

    // R1 / R2: sweep arithmetic and logic
    for (int i = 0; i < 48; i++) begin
      for (int j = 0; j < 48; j++) begin
        logic [15:0] a, b;
        a = val(i); b = val(j);
        run(5'd1, 8'h00, a, b, 16'h1234); chk("R1 add", {15'd0, acc_we, acc_res}, {15'd0, 1'b1, 16'(a + b)});
        run(5'd2, 8'h00, a, b, 16'h1234); chk("R1 sub", {15'd0, acc_we, acc_res}, {15'd0, 1'b1, 16'(a - b)});
        run(5'd3, 8'h00, a, b, 16'h1234); chk("R1 and", {acc_res}, {16'd0, a & b});
        run(5'd4, 8'h00, a, b, 16'h1234); chk("R1 ior", {acc_res}, {16'd0, a | b});
        run(5'd5, 8'h00, a, b, 16'h1234); chk("R1 xor", {15'd0, idx_we, acc_res}, {16'd0, a ^ b});
      end
      run(5'd6, 8'h00, val(i), 16'h5555, 16'h0); chk("R2 inv", {15'd0, acc_we, acc_res}, {15'd0, 1'b1, ~val(i)});
      run(5'd7, 8'h00, val(i), 16'h5555, 16'h0); chk("R2 neg", {15'd0, acc_we, acc_res}, {15'd0, 1'b1, 16'(17'h10000 - val(i))});
    end

    // R3 / R4: every count on every shift opcode
    for (int op = 8; op <= 15; op++) begin
      for (int n = 1; n <= 16; n++) begin
        for (int k = 0; k < 16; k++) begin
          logic [15:0] a, x;
          logic [31:0] e32;
          a = val(k); x = val(k + 20);
          run(5'(op), 8'(n - 1) | 8'hA0, a, 16'hFFFF, x);
          if (op < 12) begin
            chk("R3 shift16", {acc_we, idx_we, acc_res, 14'd0}, {1'b1, 1'b0, exp_sh16(op, a, n), 14'd0});
            chk("R3 idx untouched", {16'd0, idx_res}, {16'd0, x});
          end else begin
            e32 = exp_sh32(op, {a, x}, n);
            chk("R4 shift32", {acc_res, idx_res}, e32);
            chk("R4 both write", {30'd0, acc_we, idx_we}, 32'd3);
          end
        end
      end
    end

    // R5 word / byte / literal compares, R6 flags visible after edge
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < 24; j++) begin
        logic [15:0] a, b;
        a = val(i); b = val(j);
        run(5'd16, 8'h00, a, b, 16'h0);
        chk("R5 cmw nowrite", {30'd0, acc_we, idx_we}, 32'd0);
        idle();
        chk("R5 cmw flags", {29'd0, flag_lt, flag_eq, flag_gt}, {29'd0, exp_flags(int'(a), int'(b))});
        run(5'd17, 8'h00, {b[7:0], a[7:0]}, {a[7:0], b[7:0]}, 16'h0);
        idle();
        chk("R5 cmb low byte", {29'd0, flag_lt, flag_eq, flag_gt}, {29'd0, exp_flags(int'(a[7:0]), int'(b[7:0]))});
        run(5'd18, b[7:0], {8'hFF ^ a[15:8], a[7:0]}, 16'h0, 16'h0);
        idle();
        chk("R5 clb literal", {29'd0, flag_lt, flag_eq, flag_gt}, {29'd0, exp_flags(int'(a[7:0]), int'(b[7:0]))});
      end
    end

    // R6 flags persist across non-compare cycles
    run(5'd16, 8'h00, 16'h0003, 16'h0009, 16'h0);
    run(5'd1, 8'h00, 16'h0009, 16'h0003, 16'h0);
    run(5'd19, 8'h09, 16'h0, 16'h0, 16'h0);
    run(5'd20, 8'h05, 16'h0, 16'h0, 16'h0);
    chk("R6 persist lt", {29'd0, flag_lt, flag_eq, flag_gt}, 32'd4);
    chk("R8 skip on lt", {31'd0, skip}, 32'd1);
    @(negedge clk); exec_valid = 1'b0; op_code = 5'd16; acc_in = 16'h9; mbr_in = 16'h3; #1;
    @(negedge clk); #1;
    chk("R6 gated compare ignored", {29'd0, flag_lt, flag_eq, flag_gt}, 32'd4);

    // R7 literal load
    for (int b = 0; b < 256; b += 17) begin
      run(5'd19, 8'(b), 16'hBEEF, 16'h1111, 16'h2222);
      chk("R7 llb", {15'd0, acc_we, acc_res}, {15'd0, 1'b1, 8'h00, 8'(b)});
    end

    // R8 skip conditions on accumulator / index
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a, x;
      a = val(k); x = val(15 - k);
      for (int c = 0; c < 5; c++) begin
        logic e;
        case (c)
          0: e = (a == 0);
          1: e = (a != 0);
          2: e = a[15];
          3: e = (x == 0);
          default: e = x[15];
        endcase
        run(5'd20, 8'(c), a, 16'h0, x);
        chk("R8 skip acc/idx", {29'd0, acc_we, idx_we, skip}, {31'd0, e});
      end
    end

    // R8 skip on flags for each compare outcome
    for (int t = 0; t < 3; t++) begin
      logic [15:0] a;
      a = (t == 0) ? 16'h0001 : (t == 1) ? 16'h0005 : 16'h0009;
      run(5'd16, 8'h00, a, 16'h0005, 16'h0);
      for (int c = 5; c <= 7; c++) begin
        run(5'd20, 8'(c), 16'h0, 16'h0, 16'h0);
        chk("R8 skip flag", {31'd0, skip}, {31'd0, (c - 5) == t});
      end
    end

    // R8 switches and never-codes, every switch pattern
    for (int s = 0; s < 16; s++) begin
      for (int c = 8; c < 16; c++) begin
        @(negedge clk);
        sw_in = 4'(s);
        exec_valid = 1'b1; op_code = 5'd20; fld_imm = 8'(c) | 8'hF0;
        #1;
        chk("R8 skip switch", {31'd0, skip}, {31'd0, (c < 12) ? s[c - 8] : 1'b0});
      end
    end
    sw_in = 4'hF;
    @(negedge clk); exec_valid = 1'b0; op_code = 5'd20; fld_imm = 8'h08; #1;
    chk("R9 skip gated", {31'd0, skip}, 32'd0);

    // R9 unused opcodes and gated valid
    for (int op = 21; op < 33; op++) begin
      logic [4:0] o;
      o = (op == 32) ? 5'd0 : 5'(op);
      run(o, 8'h0F, 16'h1357, 16'h2468, 16'h9ABC);
      chk("R9 unused op", {acc_res, idx_res}, {16'h1357, 16'h9ABC});
      chk("R9 unused op quiet", {29'd0, acc_we, idx_we, skip}, 32'd0);
    end
    for (int op = 1; op <= 19; op++) begin
      @(negedge clk);
      exec_valid = 1'b0; op_code = 5'(op); fld_imm = 8'h03;
      acc_in = 16'h4321; mbr_in = 16'h1111; idx_in = 16'h8765;
      #1;
      chk("R9 invalid cycle", {acc_res, idx_res}, {16'h4321, 16'h8765});
      chk("R9 invalid quiet", {29'd0, acc_we, idx_we, skip}, 32'd0);
    end

    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule